// File: doc/BRIEF.md
# Context-Adaptive Predictor and Rice-Parameter Estimator

This block is the front stage of a multi-channel lossless compressor. An upstream arbiter hands it one sample at a time. Each sample carries a channel code, a precision code and a raw-pass flag. The stage forms a prediction error and folds it onto the non-negative integers. It also picks a Rice parameter k from running statistics kept separately for every channel. The error, k and the sample's tags then go to the entropy coder downstream.

Non-imaging channels are predicted from their own previous sample. k for these channels adapts from an accumulated error sum and a sample count. The imaging channel is predicted from the same pixel of the previous frame and always uses a fixed k.

The stage works in two cycles. In the accept cycle it selects the context and reads its statistics. In the next cycle it computes the error and k and writes the updated statistics back. A write-back that is still in flight is forwarded to a read of the same context, so the stage accepts one sample per cycle even when consecutive samples belong to the same channel. Both edges use a valid/acknowledge handshake.

Top module: `rice_ctx_predictor`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: For channel codes other than the imaging code (5), the prediction is the last non-raw sample accepted on the same channel, or zero if that channel has had none since reset. Channels never share this history.
- R3: The precision code c selects the sample width P: P = 8+2c for c = 0..6, and P = 32 for c = 7. The input is masked to P bits. The error e = x − prediction is folded to 2e when e ≥ 0 and to −2e−1 when e < 0. The folded value is kept to its low P bits and placed on `out_err`.
- R4: For non-imaging, non-raw samples, `out_k` is the smallest k for which (N << k) ≥ A. A and N are that channel's statistics before the current sample. The result is capped at P−1. After the sample, A grows by the folded error and N by one. When N reaches 64, both A and N are halved, so N becomes 32. A and N are zero after reset.
- R5: Imaging samples (code 5) are predicted from the same pixel of the previous frame. The pixel index counts the non-raw imaging samples accepted, modulo the frame size, and every pixel starts at zero. These samples get k = 2 and leave the per-channel statistics untouched.
- R6: When `in_byp` is high, `out_err` carries the masked raw sample and `out_k` is 0. No prediction history, statistic or pixel index changes.
- R7: `out_ch`, `out_prec` and `out_byp` repeat the tags of the sample. Results leave in the order their samples were accepted.
- R8: While `out_valid` is high and `out_ack` is low, every output holds its value.
- R9: While `out_ack` is high, `in_ready` is high. Back-to-back samples on one channel therefore flow at one per cycle and still see the statistics written by their predecessor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | The stage takes the offered sample at this edge |
| in_data | input | 32 | Sample value; bits above the precision are ignored |
| in_ch | input | 4 | Channel code (0–8; 5 is the imaging channel) |
| in_prec | input | 3 | Precision code |
| in_byp | input | 1 | Pass the sample raw, with no prediction |
| out_valid | output | 1 | A result is presented |
| out_ack | input | 1 | Downstream takes the result at this edge |
| out_err | output | 32 | Folded error, or the raw sample when passed raw |
| out_k | output | 5 | Rice parameter |
| out_ch | output | 4 | Channel code of the result |
| out_prec | output | 3 | Precision code of the result |
| out_byp | output | 1 | Raw-pass flag of the result |

## Verification
The assertions assume the arbiter never offers a channel code of 9 or above and never withdraws or changes a sample before `in_ready` takes it. The stimulus draws channels only from 0 to 8 and holds each sample on the inputs until it is accepted. The other checked properties rest on these assumptions: bounded k, error width, fixed k for imaging and raw samples, output hold, and ready while acknowledged. Stimulus runs several phases: full-rate same-channel streams, random gaps, random back-pressure, and a long single-channel run that crosses the halving point repeatedly. Under all of them the error and k values must follow the arithmetic above.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
   localparam int SAMPLE_W = 32;
   localparam int CH_W     = 4;
   localparam int PREC_W   = 3;
   localparam int K_W      = 5;

   typedef struct packed {
      logic [CH_W-1:0]   ch;
      logic [PREC_W-1:0] prec;
      logic              byp;
   } tag_t;

   // Width in bits selected by a precision code.
   function automatic int unsigned prec_width(input logic [PREC_W-1:0] code);
      return (code == PREC_W'(7)) ? 32 : 8 + 2 * int'(code);
   endfunction

   function automatic logic [SAMPLE_W-1:0] prec_mask(input logic [PREC_W-1:0] code);
      int unsigned w;
      w = prec_width(code);
      if (w >= SAMPLE_W) return '1;
      return (SAMPLE_W'(1) << w) - SAMPLE_W'(1);
   endfunction
endpackage

// File: rtl/rcp_kest.sv
module rcp_kest
   import rcp_pkg::*;
#(
   parameter int AW = 38,
   parameter int NW = 7
) (
   input  logic [AW-1:0]     acc,
   input  logic [NW-1:0]     cnt,
   input  logic [PREC_W-1:0] prec,
   output logic [K_W-1:0]    k
);
   localparam int EW = AW + SAMPLE_W;

   if (NW > AW) begin : g_chk
      $error("rcp_kest: count wider than accumulator");
   end

   logic [K_W-1:0] k_raw;
   logic [K_W-1:0] k_cap;

   // Descending scan leaves the smallest shift that covers the sum.
   always_comb begin
      k_raw = K_W'(SAMPLE_W - 1);
      for (int j = SAMPLE_W - 1; j >= 0; j--) begin
         if ((EW'(cnt) << j) >= EW'(acc)) k_raw = K_W'(j);
      end
      k_cap = K_W'(prec_width(prec) - 1);
      k     = (k_raw > k_cap) ? k_cap : k_raw;
   end
endmodule

// File: rtl/rcp_ctxmem.sv
module rcp_ctxmem #(
   parameter int DEPTH   = 9,
   parameter int IW      = 4,
   parameter int DW      = 77,
   parameter bit FORWARD = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data
);
   if (DEPTH < 1 || DEPTH > (1 << IW)) begin : g_chk
      $error("rcp_ctxmem: depth does not fit the index width");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] stored;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   assign stored = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;

   if (FORWARD) begin : g_fwd
      assign rd_data = (wr_en && wr_idx == rd_idx) ? wr_data : stored;
   end else begin : g_plain
      assign rd_data = stored;
   end
endmodule

// File: rtl/rice_ctx_predictor.sv
module rice_ctx_predictor
   import rcp_pkg::*;
#(
   parameter int NUM_CH    = 9,
   parameter int IMG_CH    = 5,
   parameter int FRAME_PIX = 16,
   parameter int IMG_K     = 2,
   parameter int N_LIMIT   = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_data,
   input  logic [CH_W-1:0]     in_ch,
   input  logic [PREC_W-1:0]   in_prec,
   input  logic                in_byp,
   output logic                out_valid,
   input  logic                out_ack,
   output logic [SAMPLE_W-1:0] out_err,
   output logic [K_W-1:0]      out_k,
   output logic [CH_W-1:0]     out_ch,
   output logic [PREC_W-1:0]   out_prec,
   output logic                out_byp
);
   localparam int NW     = $clog2(N_LIMIT) + 1;
   localparam int AW     = SAMPLE_W + $clog2(N_LIMIT);
   localparam int CTX_W  = SAMPLE_W + AW + NW;
   localparam int PIX_IW = (FRAME_PIX > 1) ? $clog2(FRAME_PIX) : 1;

   if (NUM_CH < 1 || NUM_CH > (1 << CH_W)) begin : g_chk_ch
      $error("rice_ctx_predictor: channel count out of range");
   end
   if (IMG_CH < 0 || IMG_CH >= NUM_CH) begin : g_chk_img
      $error("rice_ctx_predictor: imaging channel outside the channel range");
   end
   if (N_LIMIT < 2 || (N_LIMIT & (N_LIMIT - 1)) != 0) begin : g_chk_n
      $error("rice_ctx_predictor: count limit must be a power of two");
   end
   if (IMG_K < 0 || IMG_K > 7) begin : g_chk_k
      $error("rice_ctx_predictor: fixed k exceeds the narrowest precision");
   end
   if (FRAME_PIX < 1) begin : g_chk_pix
      $error("rice_ctx_predictor: frame needs at least one pixel");
   end

   // ---------------- stage 1: accept, context read ----------------
   logic                s1_valid, s1_adv, accept, in_is_img;
   logic [SAMPLE_W-1:0] s1_x, s1_pred;
   tag_t                s1_tag;
   logic [AW-1:0]       s1_a;
   logic [NW-1:0]       s1_n;
   logic [PIX_IW-1:0]   s1_pix, pix_cnt;

   logic [CTX_W-1:0]    ctx_rd, ctx_wr;
   logic [SAMPLE_W-1:0] pix_rd;
   logic                ctx_we, pix_we;

   assign s1_adv    = s1_valid && (!out_valid || out_ack);
   assign in_ready  = !s1_valid || s1_adv;
   assign accept    = in_valid && in_ready;
   assign in_is_img = (in_ch == CH_W'(IMG_CH));

   rcp_ctxmem #(.DEPTH(NUM_CH), .IW(CH_W), .DW(CTX_W), .FORWARD(1'b1)) u_ctx (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(in_ch), .rd_data(ctx_rd),
      .wr_en(ctx_we), .wr_idx(s1_tag.ch), .wr_data(ctx_wr)
   );

   rcp_ctxmem #(.DEPTH(FRAME_PIX), .IW(PIX_IW), .DW(SAMPLE_W), .FORWARD(1'b1)) u_pix (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(pix_cnt), .rd_data(pix_rd),
      .wr_en(pix_we), .wr_idx(s1_pix), .wr_data(s1_x)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_cnt <= '0;
      end else if (accept && in_is_img && !in_byp) begin
         pix_cnt <= (pix_cnt == PIX_IW'(FRAME_PIX - 1)) ? '0 : pix_cnt + PIX_IW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_x     <= '0;
         s1_pred  <= '0;
         s1_tag   <= '0;
         s1_a     <= '0;
         s1_n     <= '0;
         s1_pix   <= '0;
      end else if (accept) begin
         s1_valid <= 1'b1;
         s1_x     <= in_data & prec_mask(in_prec);
         s1_tag   <= '{ch: in_ch, prec: in_prec, byp: in_byp};
         s1_pred  <= in_byp ? '0 : (in_is_img ? pix_rd : ctx_rd[CTX_W-1 -: SAMPLE_W]);
         s1_a     <= ctx_rd[NW +: AW];
         s1_n     <= ctx_rd[NW-1:0];
         s1_pix   <= pix_cnt;
      end else if (s1_adv) begin
         s1_valid <= 1'b0;
      end
   end

   // ---------------- stage 2: fold, estimate, write back ----------------
   logic signed [SAMPLE_W+1:0] diff;
   logic [SAMPLE_W-1:0]        folded, err_s2;
   logic [K_W-1:0]             k_est, k_s2;
   logic [AW-1:0]              a_sum, a_new;
   logic [NW-1:0]              n_inc, n_new;
   logic                       s1_img;

   assign s1_img = (s1_tag.ch == CH_W'(IMG_CH));
   assign diff   = $signed({2'b00, s1_x}) - $signed({2'b00, s1_pred});
   assign folded = (diff[SAMPLE_W+1] ? {~diff[SAMPLE_W-2:0], 1'b1} : {diff[SAMPLE_W-2:0], 1'b0})
                   & prec_mask(s1_tag.prec);

   rcp_kest #(.AW(AW), .NW(NW)) u_kest (
      .acc(s1_a), .cnt(s1_n), .prec(s1_tag.prec), .k(k_est)
   );

   always_comb begin
      a_sum = s1_a + AW'(folded);
      n_inc = s1_n + NW'(1);
      if (n_inc == NW'(N_LIMIT)) begin
         a_new = a_sum >> 1;
         n_new = NW'(N_LIMIT / 2);
      end else begin
         a_new = a_sum;
         n_new = n_inc;
      end
      err_s2 = s1_tag.byp ? s1_x : folded;
      k_s2   = s1_tag.byp ? '0 : (s1_img ? K_W'(IMG_K) : k_est);
   end

   assign ctx_we = s1_adv && !s1_tag.byp && !s1_img;
   assign pix_we = s1_adv && !s1_tag.byp && s1_img;
   assign ctx_wr = {s1_x, a_new, n_new};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_err   <= '0;
         out_k     <= '0;
         out_ch    <= '0;
         out_prec  <= '0;
         out_byp   <= 1'b0;
      end else if (s1_adv) begin
         out_valid <= 1'b1;
         out_err   <= err_s2;
         out_k     <= k_s2;
         out_ch    <= s1_tag.ch;
         out_prec  <= s1_tag.prec;
         out_byp   <= s1_tag.byp;
      end else if (out_ack) begin
         out_valid <= 1'b0;
      end
   end

   // ---------------- assertions ----------------
   a_r2_ch_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> int'(in_ch) < NUM_CH);

   a_r3_err_fits: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_err & ~prec_mask(out_prec)) == '0);

   a_r4_k_capped: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> int'(out_k) < int'(prec_width(out_prec)));

   a_r5_img_fixed_k: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_byp && out_ch == CH_W'(IMG_CH)) |-> out_k == K_W'(IMG_K));

   a_r6_raw_k_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_byp) |-> out_k == '0);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ack) |=> (out_valid && $stable(out_err) && $stable(out_k)
                                   && $stable(out_ch) && $stable(out_prec) && $stable(out_byp)));

   a_r9_ready_when_acked: assert property (@(posedge clk) disable iff (!rst_n)
      out_ack |-> in_ready);
endmodule

// File: tb/rice_ctx_predictor_tb.sv
module rice_ctx_predictor_tb;
   localparam int NS      = 2700;
   localparam int NDIR    = 14;
   localparam int NRAND   = 2400;
   localparam int FRAME   = 4;
   localparam int IMGCH   = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic [3:0]  in_ch = '0;
   logic [2:0]  in_prec = '0;
   logic        in_byp = 1'b0;
   logic        out_valid;
   logic        out_ack = 1'b0;
   logic [31:0] out_err;
   logic [4:0]  out_k;
   logic [3:0]  out_ch;
   logic [2:0]  out_prec;
   logic        out_byp;

   always #2 clk = ~clk;

   rice_ctx_predictor #(.FRAME_PIX(FRAME)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_ch(in_ch), .in_prec(in_prec), .in_byp(in_byp),
      .out_valid(out_valid), .out_ack(out_ack), .out_err(out_err), .out_k(out_k),
      .out_ch(out_ch), .out_prec(out_prec), .out_byp(out_byp)
   );

   int tests = 0;
   int fails = 0;

   // stimulus
   logic [31:0] st_data [NS];
   logic [3:0]  st_ch   [NS];
   logic [2:0]  st_prec [NS];
   logic        st_byp  [NS];
   int          st_gap  [NS];
   logic        st_ackr [NS];
   string       st_tag  [NS];

   // expected results
   logic [31:0] ex_err  [NS];
   logic [4:0]  ex_k    [NS];
   logic [3:0]  ex_ch   [NS];
   logic [2:0]  ex_prec [NS];
   logic        ex_byp  [NS];
   string       ex_tag  [NS];

   // reference state
   longint m_prev [9];
   longint m_acc  [9];
   longint m_cnt  [9];
   longint m_pix  [FRAME];
   int     m_pc = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model(input int i);
      int     p;
      longint mask, x, pred, e, m, kk;
      p    = (st_prec[i] == 3'd7) ? 32 : 8 + 2 * int'(st_prec[i]);
      mask = (longint'(1) << p) - 1;
      x    = longint'(st_data[i]) & mask;
      ex_ch[i] = st_ch[i]; ex_prec[i] = st_prec[i]; ex_byp[i] = st_byp[i];
      ex_tag[i] = st_tag[i];
      if (st_byp[i]) begin
         ex_err[i] = 32'(x); ex_k[i] = '0;
         return;
      end
      if (int'(st_ch[i]) == IMGCH) begin
         pred = m_pix[m_pc];
      end else begin
         pred = m_prev[st_ch[i]];
      end
      e = x - pred;
      m = (e >= 0) ? 2 * e : -2 * e - 1;
      m = m & mask;
      ex_err[i] = 32'(m);
      if (int'(st_ch[i]) == IMGCH) begin
         ex_k[i] = 5'd2;
         m_pix[m_pc] = x;
         m_pc = (m_pc + 1) % FRAME;
      end else begin
         kk = 31;
         for (int j = 31; j >= 0; j--) begin
            if ((m_cnt[st_ch[i]] << j) >= m_acc[st_ch[i]]) kk = j;
         end
         if (kk > p - 1) kk = p - 1;
         ex_k[i] = 5'(kk);
         m_acc[st_ch[i]] = m_acc[st_ch[i]] + m;
         m_cnt[st_ch[i]] = m_cnt[st_ch[i]] + 1;
         if (m_cnt[st_ch[i]] == 64) begin
            m_acc[st_ch[i]] = m_acc[st_ch[i]] >> 1;
            m_cnt[st_ch[i]] = 32;
         end
         m_prev[st_ch[i]] = x;
      end
   endtask

   task automatic put(input int i, input logic [3:0] ch, input logic [2:0] pr,
                      input logic byp, input logic [31:0] d, input int gap,
                      input logic ackr, input string tag);
      st_ch[i] = ch; st_prec[i] = pr; st_byp[i] = byp; st_data[i] = d;
      st_gap[i] = gap; st_ackr[i] = ackr; st_tag[i] = tag;
   endtask

   initial begin
      int i;
      for (int c = 0; c < 9; c++) begin m_prev[c] = 0; m_acc[c] = 0; m_cnt[c] = 0; end
      for (int q = 0; q < FRAME; q++) m_pix[q] = 0;
      // directed phase, full rate
      put(0,  4'd0, 3'd0, 1'b0, 32'd5,        0, 1'b0, "R2");
      put(1,  4'd0, 3'd0, 1'b0, 32'd9,        0, 1'b0, "R9");
      put(2,  4'd1, 3'd0, 1'b0, 32'd3,        0, 1'b0, "R2");
      put(3,  4'd0, 3'd0, 1'b0, 32'd2,        0, 1'b0, "R3");
      put(4,  4'd0, 3'd0, 1'b1, 32'h1FF,      0, 1'b0, "R6");
      put(5,  4'd0, 3'd0, 1'b0, 32'd2,        0, 1'b0, "R6");
      put(6,  4'd2, 3'd7, 1'b0, 32'hFFFFFFFF, 0, 1'b0, "R3");
      put(7,  4'd2, 3'd7, 1'b0, 32'd0,        0, 1'b0, "R3");
      put(8,  4'd5, 3'd4, 1'b0, 32'd100,      0, 1'b0, "R5");
      put(9,  4'd5, 3'd4, 1'b0, 32'd7,        0, 1'b0, "R5");
      put(10, 4'd5, 3'd4, 1'b1, 32'd8,        0, 1'b0, "R6");
      put(11, 4'd5, 3'd4, 1'b0, 32'd9,        0, 1'b0, "R5");
      put(12, 4'd5, 3'd4, 1'b0, 32'd11,       0, 1'b0, "R5");
      put(13, 4'd3, 3'd2, 1'b0, 32'hFFFF,     0, 1'b0, "R3");
      // random phase with gaps and back-pressure
      for (int r = 0; r < NRAND; r++) begin
         logic [3:0]  ch;
         logic        byp;
         logic [31:0] d;
         ch  = 4'($urandom % 9);
         byp = ($urandom % 8) == 0;
         d   = ($urandom % 3 == 0) ? $urandom : ($urandom % 64);
         put(NDIR + r, ch, 3'($urandom % 8), byp, d, int'($urandom % 3),
             1'b1, byp ? "R6" : ((int'(ch) == IMGCH) ? "R5" : "R4"));
      end
      // long single-channel stream crossing the halving point
      for (i = NDIR + NRAND; i < NS; i++) begin
         put(i, 4'd7, 3'd4, 1'b0, 32'($urandom % 4096), 0, 1'b0, "R4");
      end
   end

   int  idx = 0, rd = 0, gap_left = 0, cyc = 0, r9_stalls = 0;
   bit  hold_pend = 0;
   logic [31:0] h_err; logic [4:0] h_k; logic [3:0] h_ch; logic [2:0] h_prec; logic h_byp;

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1,  "R1", "in_ready after reset", in_ready, 1);
      @(negedge clk);
      rst_n = 1'b1;
      gap_left = st_gap[0];
      while (rd < NS) begin
         @(negedge clk);
         cyc++;
         if (cyc > 60000) begin
            check(1'b0, "R7", "watchdog expired, results received", rd, NS);
            break;
         end
         if (idx < NS && st_ackr[idx]) out_ack = ($urandom % 3) != 0;
         else out_ack = 1'b1;
         if (idx < NS && gap_left == 0) begin
            in_valid = 1'b1;
            in_data = st_data[idx]; in_ch = st_ch[idx];
            in_prec = st_prec[idx]; in_byp = st_byp[idx];
         end else begin
            in_valid = 1'b0;
            if (gap_left > 0) gap_left--;
         end
         #1;
         if (hold_pend) begin
            check(out_valid && out_err == h_err && out_k == h_k && out_ch == h_ch
                  && out_prec == h_prec && out_byp == h_byp,
                  "R8", "held output", {out_valid, out_err}, {1'b1, h_err});
            hold_pend = 0;
         end
         if (out_ack && !in_ready) r9_stalls++;
         if (out_valid && out_ack) begin
            check(out_err == ex_err[rd], ex_tag[rd], $sformatf("error of result %0d", rd),
                  out_err, ex_err[rd]);
            check(out_k == ex_k[rd], (ex_tag[rd] == "R3" || ex_tag[rd] == "R2") ? "R4" : ex_tag[rd],
                  $sformatf("k of result %0d", rd), out_k, ex_k[rd]);
            check(out_ch == ex_ch[rd] && out_prec == ex_prec[rd] && out_byp == ex_byp[rd],
                  "R7", $sformatf("tags of result %0d", rd),
                  {out_ch, out_prec, out_byp}, {ex_ch[rd], ex_prec[rd], ex_byp[rd]});
            rd++;
         end else if (out_valid) begin
            hold_pend = 1;
            h_err = out_err; h_k = out_k; h_ch = out_ch; h_prec = out_prec; h_byp = out_byp;
         end
         if (in_valid && in_ready) begin
            model(idx);
            idx++;
            if (idx < NS) gap_left = st_gap[idx];
         end
      end
      check(r9_stalls == 0, "R9", "ready dropped while acknowledged", r9_stalls, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule